// File: doc/BRIEF.md
# Ethernet Reply Header Builder

The block turns the parsed header of a received Ethernet frame into the header of the frame that answers it. Instead of assembling a reply from configured values, it reuses what arrived: MAC addresses, IP addresses and UDP ports are swapped, and the ARP operation and the ICMP message type are rewritten from request to reply. Every other field, checksums included, passes through unchanged. Recomputing checksums, copying payload and generating the CRC are left to the surrounding logic.

A request presents all header fields in parallel, together with a two-bit kind selector: 0 raw Ethernet, 1 ARP, 2 IPv4/ICMP echo, 3 IPv4/UDP. The request is taken on any cycle where `req_valid` and `req_ready` are both high. A request that fails the acceptance rules is consumed and produces nothing. A request that passes is streamed out as 32-bit words, most significant byte first. The stream opens with the 16-bit alignment prefix, and each word is handed to a transmit buffer under a valid/ready handshake.

Top module: `eth_reply_hdr`

## Requirements
- R1: After a synchronous reset cycle, `out_valid` is 0 and `req_ready` is 1.
- R2: The first four output words form the Ethernet part. Word 0 is {alignment[15:0], rx source MAC[47:32]}. Word 1 is rx source MAC[31:0]. Word 2 is rx destination MAC[47:16]. Word 3 is {rx destination MAC[15:0], EtherType}.
- R3: Only EtherType 0x0806 (ARP) or 0x0800 (IPv4) can produce output. A request with any other EtherType is consumed with no output word, and `req_ready` is high again the cycle after it is taken.
- R4: Kind 0 (raw) with an accepted EtherType emits exactly the 4 Ethernet words, and `out_last` is high on word 3.
- R5: Kind 1 (ARP) emits 11 words. Word 4 is {hw type, proto type}. Word 5 is {hw len, proto len, 16'h0002}. Word 6 is rx target HW[47:16]. Word 7 is {rx target HW[15:0], rx target IP[31:16]}. Word 8 is {rx target IP[15:0], rx sender HW[47:32]}. Word 9 is rx sender HW[31:0]. Word 10 is rx sender IP.
- R6: Kind 1 is answered only if the EtherType is 0x0806 and the operation is 1. Otherwise the request is dropped with no output.
- R7: Kinds 2 and 3 emit 11 words with the IPv4 header in words 4 to 8. Word 4 is {version, IHL, services, total length}. Word 5 is {identification, flags[2:0], fragment offset[12:0]}. Word 6 is {TTL, protocol, checksum}. Word 7 is the rx destination IP. Word 8 is the rx source IP.
- R8: Kind 2 (ICMP) puts {8'h00, code, checksum} in word 9 and {identifier, sequence} in word 10.
- R9: Kind 3 (UDP) puts {rx destination port, rx source port} in word 9 and {length, checksum} in word 10.
- R10: Kind 2 needs EtherType 0x0800, protocol 1 and ICMP type 8. Kind 3 needs EtherType 0x0800 and protocol 17. A request that fails its check is dropped with no output.
- R11: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold. `req_ready` is low while words are pending. After the word carrying `out_last` is taken, `out_valid` falls and `req_ready` rises on the next cycle.
- R12: A reset in the middle of a header discards the rest of it, and the next request is emitted completely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request fields are valid |
| req_ready | output | 1 | Block can take a request |
| req_kind | input | 2 | 0 raw, 1 ARP, 2 ICMP, 3 UDP |
| rx_align | input | 16 | Alignment prefix |
| rx_dst_mac | input | 48 | Received destination MAC |
| rx_src_mac | input | 48 | Received source MAC |
| rx_etype | input | 16 | Received EtherType |
| arp_hw_type | input | 16 | ARP hardware type |
| arp_pr_type | input | 16 | ARP protocol type |
| arp_hw_len | input | 8 | ARP hardware address length |
| arp_pr_len | input | 8 | ARP protocol address length |
| arp_op | input | 16 | ARP operation |
| arp_snd_hw | input | 48 | ARP sender hardware address |
| arp_snd_ip | input | 32 | ARP sender protocol address |
| arp_tgt_hw | input | 48 | ARP target hardware address |
| arp_tgt_ip | input | 32 | ARP target protocol address |
| ip_ver | input | 4 | IPv4 version |
| ip_ihl | input | 4 | IPv4 header length |
| ip_tos | input | 8 | IPv4 services |
| ip_len | input | 16 | IPv4 total length |
| ip_id | input | 16 | IPv4 identification |
| ip_flags | input | 3 | IPv4 flags |
| ip_frag | input | 13 | IPv4 fragment offset |
| ip_ttl | input | 8 | IPv4 time to live |
| ip_proto | input | 8 | IPv4 protocol |
| ip_csum | input | 16 | IPv4 header checksum |
| ip_src | input | 32 | IPv4 source address |
| ip_dst | input | 32 | IPv4 destination address |
| icmp_type | input | 8 | ICMP message type |
| icmp_code | input | 8 | ICMP code |
| icmp_csum | input | 16 | ICMP checksum |
| icmp_id | input | 16 | ICMP identifier |
| icmp_seq | input | 16 | ICMP sequence number |
| udp_src | input | 16 | UDP source port |
| udp_dst | input | 16 | UDP destination port |
| udp_len | input | 16 | UDP length |
| udp_csum | input | 16 | UDP checksum |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Transmit buffer takes the word |
| out_data | output | 32 | Output header word |
| out_last | output | 1 | Final word of the header |

## Verification
The hardest situation to reach from the ports is a drop that has to be told apart from a late start. A rejected request must leave `out_valid` low and `req_ready` high on the very next cycle. A design that wrongly begins a header would raise `out_valid` at exactly that moment, so the bench checks that cycle directly. The bench sweeps every combination of kind, three EtherTypes, three IP protocols, and request versus non-request opcodes, with pseudo-random field contents. This covers every acceptance rule in both directions. It also stalls `out_ready` on a rotating set of word positions to check that the held word stays stable, and it drives a reset two words into a UDP header.

// File: rtl/eth_reply_hdr.sv
module eth_reply_hdr #(
  parameter logic [15:0] ETYPE_ARP  = 16'h0806,
  parameter logic [15:0] ETYPE_IPV4 = 16'h0800,
  parameter logic [7:0]  PROTO_ICMP = 8'd1,
  parameter logic [7:0]  PROTO_UDP  = 8'd17,
  parameter logic [7:0]  ICMP_ECHO_REQ = 8'd8,
  parameter logic [7:0]  ICMP_ECHO_REP = 8'd0,
  parameter logic [15:0] ARP_OP_REQ = 16'd1,
  parameter logic [15:0] ARP_OP_REP = 16'd2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [1:0]  req_kind,
  input  logic [15:0] rx_align,
  input  logic [47:0] rx_dst_mac,
  input  logic [47:0] rx_src_mac,
  input  logic [15:0] rx_etype,
  input  logic [15:0] arp_hw_type,
  input  logic [15:0] arp_pr_type,
  input  logic [7:0]  arp_hw_len,
  input  logic [7:0]  arp_pr_len,
  input  logic [15:0] arp_op,
  input  logic [47:0] arp_snd_hw,
  input  logic [31:0] arp_snd_ip,
  input  logic [47:0] arp_tgt_hw,
  input  logic [31:0] arp_tgt_ip,
  input  logic [3:0]  ip_ver,
  input  logic [3:0]  ip_ihl,
  input  logic [7:0]  ip_tos,
  input  logic [15:0] ip_len,
  input  logic [15:0] ip_id,
  input  logic [2:0]  ip_flags,
  input  logic [12:0] ip_frag,
  input  logic [7:0]  ip_ttl,
  input  logic [7:0]  ip_proto,
  input  logic [15:0] ip_csum,
  input  logic [31:0] ip_src,
  input  logic [31:0] ip_dst,
  input  logic [7:0]  icmp_type,
  input  logic [7:0]  icmp_code,
  input  logic [15:0] icmp_csum,
  input  logic [15:0] icmp_id,
  input  logic [15:0] icmp_seq,
  input  logic [15:0] udp_src,
  input  logic [15:0] udp_dst,
  input  logic [15:0] udp_len,
  input  logic [15:0] udp_csum,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_data,
  output logic        out_last
);

  localparam int WORD_W  = 32;
  localparam int NW_FULL = 11;
  localparam int NW_ETH  = 4;
  localparam int HDR_W   = WORD_W * NW_FULL;
  localparam int IDX_W   = $clog2(NW_FULL);
  localparam logic [IDX_W-1:0] LAST_FULL = IDX_W'(NW_FULL - 1);
  localparam logic [IDX_W-1:0] LAST_ETH  = IDX_W'(NW_ETH - 1);

  localparam logic [1:0] K_RAW = 2'd0, K_ARP = 2'd1, K_ICMP = 2'd2, K_UDP = 2'd3;

  logic              busy;
  logic [IDX_W-1:0]  idx, last_q;
  logic [HDR_W-1:0]  hdr_q;

  logic [127:0] eth_part;
  logic [223:0] arp_part;
  logic [159:0] ip_part;
  logic [63:0]  icmp_part, udp_part;
  logic [223:0] l3_part;
  logic         is_arp, is_ip, ok, take, adv;

  assign eth_part  = {rx_align, rx_src_mac, rx_dst_mac, rx_etype};
  assign arp_part  = {arp_hw_type, arp_pr_type, arp_hw_len, arp_pr_len, ARP_OP_REP,
                      arp_tgt_hw, arp_tgt_ip, arp_snd_hw, arp_snd_ip};
  assign ip_part   = {ip_ver, ip_ihl, ip_tos, ip_len, ip_id, ip_flags, ip_frag,
                      ip_ttl, ip_proto, ip_csum, ip_dst, ip_src};
  assign icmp_part = {ICMP_ECHO_REP, icmp_code, icmp_csum, icmp_id, icmp_seq};
  assign udp_part  = {udp_dst, udp_src, udp_len, udp_csum};
  assign l3_part   = (req_kind == K_ARP) ? arp_part
                   : {ip_part, (req_kind == K_ICMP) ? icmp_part : udp_part};

  assign is_arp = (rx_etype == ETYPE_ARP);
  assign is_ip  = (rx_etype == ETYPE_IPV4);

  always_comb begin
    unique case (req_kind)
      K_RAW:   ok = is_arp || is_ip;
      K_ARP:   ok = is_arp && (arp_op == ARP_OP_REQ);
      K_ICMP:  ok = is_ip && (ip_proto == PROTO_ICMP) && (icmp_type == ICMP_ECHO_REQ);
      default: ok = is_ip && (ip_proto == PROTO_UDP);
    endcase
  end

  assign req_ready = !busy;
  assign take      = req_valid && !busy;
  assign adv       = busy && out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      idx    <= '0;
      last_q <= '0;
    end else if (take) begin
      if (ok) begin
        busy   <= 1'b1;
        idx    <= '0;
        last_q <= (req_kind == K_RAW) ? LAST_ETH : LAST_FULL;
        hdr_q  <= {eth_part, l3_part};
      end
    end else if (adv) begin
      if (idx == last_q) begin
        busy <= 1'b0;
      end else begin
        idx   <= idx + 1'b1;
        hdr_q <= hdr_q << WORD_W;
      end
    end
  end

  assign out_valid = busy;
  assign out_data  = hdr_q[HDR_W-1 -: WORD_W];
  assign out_last  = busy && (idx == last_q);

  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> !out_valid && req_ready);

  // R11
  hold_word_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  // R11
  last_done_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && out_last |=> !out_valid && req_ready);

  // R3
  etype_drop_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && rx_etype != ETYPE_ARP && rx_etype != ETYPE_IPV4 |=> !out_valid);

  // R10
  udp_proto_drop_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && req_kind == K_UDP && ip_proto != PROTO_UDP |=> !out_valid);

  // R2
  first_word_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> !out_valid ||
      out_data == {$past(rx_align), $past(rx_src_mac[47:32])});

endmodule

// File: tb/eth_reply_hdr_bench.sv
module eth_reply_hdr_bench;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, out_ready = 1'b0;
  logic req_ready, out_valid, out_last;
  logic [31:0] out_data;
  logic [1:0]  req_kind = '0;
  logic [15:0] rx_align = '0, rx_etype = '0;
  logic [47:0] rx_dst_mac = '0, rx_src_mac = '0;
  logic [15:0] arp_hw_type = '0, arp_pr_type = '0, arp_op = '0;
  logic [7:0]  arp_hw_len = '0, arp_pr_len = '0;
  logic [47:0] arp_snd_hw = '0, arp_tgt_hw = '0;
  logic [31:0] arp_snd_ip = '0, arp_tgt_ip = '0;
  logic [3:0]  ip_ver = '0, ip_ihl = '0;
  logic [7:0]  ip_tos = '0, ip_ttl = '0, ip_proto = '0;
  logic [15:0] ip_len = '0, ip_id = '0, ip_csum = '0;
  logic [2:0]  ip_flags = '0;
  logic [12:0] ip_frag = '0;
  logic [31:0] ip_src = '0, ip_dst = '0;
  logic [7:0]  icmp_type = '0, icmp_code = '0;
  logic [15:0] icmp_csum = '0, icmp_id = '0, icmp_seq = '0;
  logic [15:0] udp_src = '0, udp_dst = '0, udp_len = '0, udp_csum = '0;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [31:0] seed = 32'h1234_5678;
  logic [31:0] ew [0:10];

  always #(CLK_P/2) clk = ~clk;

  eth_reply_hdr u_eth_reply_hdr (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .rx_align(rx_align), .rx_dst_mac(rx_dst_mac), .rx_src_mac(rx_src_mac), .rx_etype(rx_etype),
    .arp_hw_type(arp_hw_type), .arp_pr_type(arp_pr_type), .arp_hw_len(arp_hw_len),
    .arp_pr_len(arp_pr_len), .arp_op(arp_op), .arp_snd_hw(arp_snd_hw), .arp_snd_ip(arp_snd_ip),
    .arp_tgt_hw(arp_tgt_hw), .arp_tgt_ip(arp_tgt_ip),
    .ip_ver(ip_ver), .ip_ihl(ip_ihl), .ip_tos(ip_tos), .ip_len(ip_len), .ip_id(ip_id),
    .ip_flags(ip_flags), .ip_frag(ip_frag), .ip_ttl(ip_ttl), .ip_proto(ip_proto),
    .ip_csum(ip_csum), .ip_src(ip_src), .ip_dst(ip_dst),
    .icmp_type(icmp_type), .icmp_code(icmp_code), .icmp_csum(icmp_csum), .icmp_id(icmp_id),
    .icmp_seq(icmp_seq), .udp_src(udp_src), .udp_dst(udp_dst), .udp_len(udp_len),
    .udp_csum(udp_csum), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last)
  );

  task automatic chk(input bit cond, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed ^ (seed >> 13);
  endfunction

  task automatic fill_fields();
    rx_align = rnd()[15:0]; rx_dst_mac = {rnd()[15:0], rnd()}; rx_src_mac = {rnd()[15:0], rnd()};
    arp_hw_type = rnd()[15:0]; arp_pr_type = rnd()[15:0]; arp_hw_len = rnd()[7:0]; arp_pr_len = rnd()[7:0];
    arp_snd_hw = {rnd()[15:0], rnd()}; arp_snd_ip = rnd(); arp_tgt_hw = {rnd()[15:0], rnd()}; arp_tgt_ip = rnd();
    ip_ver = rnd()[3:0]; ip_ihl = rnd()[3:0]; ip_tos = rnd()[7:0]; ip_len = rnd()[15:0]; ip_id = rnd()[15:0];
    ip_flags = rnd()[2:0]; ip_frag = rnd()[12:0]; ip_ttl = rnd()[7:0]; ip_csum = rnd()[15:0];
    ip_src = rnd(); ip_dst = rnd();
    icmp_code = rnd()[7:0]; icmp_csum = rnd()[15:0]; icmp_id = rnd()[15:0]; icmp_seq = rnd()[15:0];
    udp_src = rnd()[15:0]; udp_dst = rnd()[15:0]; udp_len = rnd()[15:0]; udp_csum = rnd()[15:0];
  endtask

  task automatic build_expect();
    ew[0] = {rx_align, rx_src_mac[47:32]};
    ew[1] = rx_src_mac[31:0];
    ew[2] = rx_dst_mac[47:16];
    ew[3] = {rx_dst_mac[15:0], rx_etype};
    if (req_kind == 2'd1) begin
      ew[4] = {arp_hw_type, arp_pr_type};
      ew[5] = {arp_hw_len, arp_pr_len, 16'h0002};
      ew[6] = arp_tgt_hw[47:16];
      ew[7] = {arp_tgt_hw[15:0], arp_tgt_ip[31:16]};
      ew[8] = {arp_tgt_ip[15:0], arp_snd_hw[47:32]};
      ew[9] = arp_snd_hw[31:0];
      ew[10] = arp_snd_ip;
    end else begin
      ew[4] = {ip_ver, ip_ihl, ip_tos, ip_len};
      ew[5] = {ip_id, ip_flags, ip_frag};
      ew[6] = {ip_ttl, ip_proto, ip_csum};
      ew[7] = ip_dst;
      ew[8] = ip_src;
      if (req_kind == 2'd2) begin
        ew[9] = {8'h00, icmp_code, icmp_csum};
        ew[10] = {icmp_id, icmp_seq};
      end else begin
        ew[9] = {udp_dst, udp_src};
        ew[10] = {udp_len, udp_csum};
      end
    end
  endtask

  function automatic string word_req(input int k);
    if (k < 4) return "R2";
    if (req_kind == 2'd1) return "R5";
    if (k < 9) return "R7";
    return (req_kind == 2'd2) ? "R8" : "R9";
  endfunction

  task automatic send_req();
    @(negedge clk);
    build_expect();
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic collect(input int n, input int stall_phase, input int upto);
    for (int k = 0; k < upto; k++) begin
      chk(out_valid === 1'b1, "R11 valid while pending", {31'd0, out_valid}, 32'd1);
      chk(req_ready === 1'b0, "R11 busy", {31'd0, req_ready}, 32'd0);
      chk(out_data === ew[k], word_req(k), out_data, ew[k]);
      chk(out_last === (k == n - 1), (n == 4) ? "R4 last" : "R11 last",
          {31'd0, out_last}, {31'd0, k == n - 1});
      if ((k + stall_phase) % 3 == 0) begin
        @(posedge clk);
        @(negedge clk);
        chk(out_valid === 1'b1 && out_data === ew[k], "R11 hold", out_data, ew[k]);
      end
      out_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      out_ready = 1'b0;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] et_tab [0:2];
    logic [7:0]  pr_tab [0:2];
    int ci;
    bit ok;
    int n;
    et_tab[0] = 16'h0806; et_tab[1] = 16'h0800; et_tab[2] = 16'h86DD;
    pr_tab[0] = 8'd1;     pr_tab[1] = 8'd17;    pr_tab[2] = 8'd6;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(out_valid === 1'b0, "R1 out_valid", {31'd0, out_valid}, 32'd0);
    chk(req_ready === 1'b1, "R1 req_ready", {31'd0, req_ready}, 32'd1);

    ci = 0;
    for (int kd = 0; kd < 4; kd++)
      for (int e = 0; e < 3; e++)
        for (int p = 0; p < 3; p++)
          for (int o = 0; o < 2; o++) begin
            fill_fields();
            req_kind = 2'(kd);
            rx_etype = et_tab[e];
            ip_proto = pr_tab[p];
            arp_op = o ? 16'd2 : 16'd1;
            icmp_type = o ? 8'd0 : 8'd8;
            case (kd)
              0: ok = (e < 2);
              1: ok = (e == 0) && (o == 0);
              2: ok = (e == 1) && (p == 0) && (o == 0);
              default: ok = (e == 1) && (p == 1);
            endcase
            n = (kd == 0) ? 4 : 11;
            send_req();
            if (ok) begin
              collect(n, ci, n);
              chk(out_valid === 1'b0, "R11 done valid", {31'd0, out_valid}, 32'd0);
              chk(req_ready === 1'b1, "R11 done ready", {31'd0, req_ready}, 32'd1);
            end else begin
              chk(out_valid === 1'b0 && req_ready === 1'b1,
                  (e == 2) ? "R3 drop" : (kd == 1) ? "R6 drop" : "R10 drop",
                  {30'd0, out_valid, req_ready}, 32'd1);
            end
            ci++;
          end

    fill_fields();
    req_kind = 2'd3; rx_etype = 16'h0800; ip_proto = 8'd17;
    send_req();
    collect(11, 1, 2);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(out_valid === 1'b0, "R12 abandon valid", {31'd0, out_valid}, 32'd0);
    chk(req_ready === 1'b1, "R12 abandon ready", {31'd0, req_ready}, 32'd1);
    fill_fields();
    req_kind = 2'd2; rx_etype = 16'h0800; ip_proto = 8'd1; icmp_type = 8'd8;
    send_req();
    collect(11, 2, 11);
    chk(out_valid === 1'b0 && req_ready === 1'b1, "R12 recovery", {30'd0, out_valid, req_ready}, 32'd1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule